// File: doc/BRIEF.md
# Descriptor-Driven Packet Transmit DMA

This block is a single-channel DMA engine that moves frames from buffers in host memory out to a MAC-side streaming port. Software builds a list of descriptors in host memory and hands each one to the engine by setting its ownership bit. The engine fetches each owned descriptor over a simple request/acknowledge memory port and decodes the buffer addresses, lengths, frame markers and chaining mode. It then streams the buffer words out with first/last frame markers, writes a completion status word back into the descriptor, and moves on to the next descriptor.

Two ways of finding the next descriptor are supported. In the two-buffer layout, descriptors sit back to back in a ring, and an end-of-ring flag wraps the ring to the list base. In the linked layout, the fourth word of a descriptor holds the address of the next one. A frame may be spread over several descriptors. A run level starts and stops the engine. A poll pulse restarts it after it has found a descriptor still owned by the host. An interrupt pulse reports finished frames and descriptor errors.

Top module: `pkt_dma_engine`

## Requirements
- R1: After reset, `stopped_o` is 1, and `suspended_o`, `mem_req_o`, `tx_valid_o` and `irq_o` are all 0.
- R2: When `run_i` rises, fetching starts at `base_i` (low four bits forced to zero). A descriptor is read as four 32-bit words at byte offsets 0, 4, 8 and 12 of its 16-byte-aligned address. If bit 31 (ownership) of word 0 is 0, the engine moves no data, writes nothing and raises `suspended_o`. A `poll_i` pulse makes it fetch the same descriptor again.
- R3: Word 1 layout: bits 11:0 hold buffer-1 length in bytes, bits 23:12 buffer-2 length, bit 24 linked mode, bit 25 end of ring, bit 26 last segment, bit 27 first segment. Word 2 holds the buffer-1 address. Word 3 holds the buffer-2 address, or the next-descriptor address in linked mode.
- R4: Buffer 1 is streamed first, then buffer 2. Each buffer gives ceil(length/4) beats, read as consecutive 32-bit words from its address. A buffer of length zero is skipped and produces no beats.
- R5: In two-buffer mode, the next descriptor is at the current address plus 16, or at the list base when the end-of-ring flag is set.
- R6: In linked mode, the next descriptor is at word 3 with its low four bits cleared, and the buffer-2 length is ignored.
- R7: `tx_first_o` is 1 on the first beat of a descriptor whose first-segment flag is set. `tx_last_o` is 1 on the final beat of a descriptor whose last-segment flag is set. A frame may span several descriptors.
- R8: After its data, each descriptor gets word 0 written back. Bit 31 is 0. Bit 30 is the error flag. Bits 12:0 hold the bytes moved: buffer-1 length plus, in two-buffer mode only, buffer-2 length, or 0 on error.
- R9: A used buffer length above 2048 is a descriptor error. No beats are sent, and the error status is written back. A length of exactly 2048 is accepted.
- R10: `irq_o` pulses for one cycle right after the write-back is acknowledged. It pulses on an error when `irq_err_en_i` is 1, or on an error-free last segment when `irq_frame_en_i` is 1.
- R11: When `run_i` falls, the current descriptor is finished, including its write-back, and then `stopped_o` rises. The following descriptor is not touched.
- R12: While `tx_valid_o` is 1 and `tx_ready_i` is 0, the stream outputs hold steady. A memory request holds its address and direction until `mem_ack_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Run level: 1 runs, 0 requests a stop |
| poll_i | input | 1 | Pulse that refetches the descriptor after a suspend |
| base_i | input | AW | Byte address of the descriptor list base |
| irq_frame_en_i | input | 1 | Interrupt enable for completed frames |
| irq_err_en_i | input | 1 | Interrupt enable for descriptor errors |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | 1 for write (status write-back), 0 for read |
| mem_addr_o | output | AW | Byte address of the 32-bit word |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request accepted; read data is valid in this cycle |
| mem_rdata_i | input | 32 | Read data |
| tx_valid_o | output | 1 | Stream beat valid |
| tx_data_o | output | 32 | Stream beat data |
| tx_first_o | output | 1 | First beat of a frame |
| tx_last_o | output | 1 | Final beat of a frame |
| tx_ready_i | input | 1 | Stream sink ready |
| irq_o | output | 1 | One-cycle interrupt pulse |
| stopped_o | output | 1 | Engine stopped |
| suspended_o | output | 1 | Engine waiting on a host-owned descriptor |

## Verification
A wrong segment counter or a bad length decode shows up at the stream port within a few beats. It appears as a missing or extra beat, or as a word from the wrong address, and the in-order beat comparison catches it at the end of the frame. A wrong next-descriptor pointer shows up one descriptor later: the ring walks to an unexpected address, which brings stray beats or leaves a status word unwritten. The stop and interrupt paths are judged by the status words left in memory and by the pulse count after the engine settles.

// File: rtl/pkt_dma_pkg.sv
package pkt_dma_pkg;
    localparam int WORD_W    = 32;
    localparam int OWN_BIT   = 31;
    localparam int ERR_BIT   = 30;
    localparam int DESC_WRDS = 4;

    typedef enum logic [2:0] {
        ST_STOP,
        ST_FETCH,
        ST_DECODE,
        ST_SEG,
        ST_RD,
        ST_OUT,
        ST_WB,
        ST_SUSP
    } dma_state_e;
endpackage

// File: rtl/pkt_dma_desc_decode.sv
module pkt_dma_desc_decode
    import pkt_dma_pkg::*;
#(
    parameter int LW        = 12,
    parameter int MAX_BYTES = 2048
) (
    input  logic [WORD_W-1:0] ctrl_i,
    output logic              chain_o,
    output logic              eor_o,
    output logic              last_o,
    output logic              first_o,
    output logic [LW-2:0]     beats1_o,
    output logic [LW-2:0]     beats2_o,
    output logic              use_buf2_o,
    output logic              len_err_o,
    output logic [LW:0]       bytes_o
);
    localparam int CHAIN_POS = 2 * LW;
    localparam int EOR_POS   = CHAIN_POS + 1;
    localparam int LAST_POS  = CHAIN_POS + 2;
    localparam int FIRST_POS = CHAIN_POS + 3;
    localparam logic [LW-1:0] MAX_L = LW'(MAX_BYTES);

    logic [LW-1:0] len1, len2;
    logic [LW:0]   sum1, sum2;

    always_comb begin
        len1       = ctrl_i[LW-1:0];
        len2       = ctrl_i[2*LW-1:LW];
        chain_o    = ctrl_i[CHAIN_POS];
        eor_o      = ctrl_i[EOR_POS];
        last_o     = ctrl_i[LAST_POS];
        first_o    = ctrl_i[FIRST_POS];
        sum1       = {1'b0, len1} + (LW+1)'(3);
        sum2       = {1'b0, len2} + (LW+1)'(3);
        beats1_o   = sum1[LW:2];
        beats2_o   = sum2[LW:2];
        use_buf2_o = !chain_o && (beats2_o != '0);
        len_err_o  = (len1 > MAX_L) || (!chain_o && (len2 > MAX_L));
        bytes_o    = {1'b0, len1} + (chain_o ? '0 : {1'b0, len2});
    end
endmodule

// File: rtl/pkt_dma_next_ptr.sv
module pkt_dma_next_ptr #(
    parameter int AW         = 32,
    parameter int DESC_BYTES = 16
) (
    input  logic [AW-1:0] cur_i,
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] link_i,
    input  logic          chain_i,
    input  logic          eor_i,
    output logic [AW-1:0] next_o
);
    localparam int AL = $clog2(DESC_BYTES);

    always_comb begin
        if (chain_i)    next_o = {link_i[AW-1:AL], {AL{1'b0}}};
        else if (eor_i) next_o = {base_i[AW-1:AL], {AL{1'b0}}};
        else            next_o = cur_i + AW'(DESC_BYTES);
    end
endmodule

// File: rtl/pkt_dma_engine.sv
module pkt_dma_engine
    import pkt_dma_pkg::*;
#(
    parameter int AW        = 32,
    parameter int LW        = 12,
    parameter int MAX_BYTES = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              poll_i,
    input  logic [AW-1:0]     base_i,
    input  logic              irq_frame_en_i,
    input  logic              irq_err_en_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [AW-1:0]     mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic              tx_valid_o,
    output logic [WORD_W-1:0] tx_data_o,
    output logic              tx_first_o,
    output logic              tx_last_o,
    input  logic              tx_ready_i,
    output logic              irq_o,
    output logic              stopped_o,
    output logic              suspended_o
);
    localparam int DESC_BYTES = DESC_WRDS * 4;
    localparam int AL         = $clog2(DESC_BYTES);
    localparam int CW         = LW - 1;
    localparam int PAD_W      = ERR_BIT - (LW + 1);

    typedef struct packed {
        dma_state_e        st;
        logic [AW-1:0]     cur;
        logic [1:0]        idx;
        logic [WORD_W-1:0] ctrl;
        logic [WORD_W-1:0] buf1;
        logic [WORD_W-1:0] link;
        logic [1:0]        seg;
        logic [CW-1:0]     cnt;
        logic [AW-1:0]     addr;
        logic [WORD_W-1:0] data;
        logic              sof;
        logic              err;
        logic              irq;
    } regs_t;

    regs_t q, d;

    logic          chain, eor, seg_last, seg_first, use_buf2, len_err;
    logic [CW-1:0] beats1, beats2;
    logic [LW:0]   bytes;
    logic [AW-1:0] next_desc;

    pkt_dma_desc_decode #(.LW(LW), .MAX_BYTES(MAX_BYTES)) u_dec (
        .ctrl_i     (q.ctrl),
        .chain_o    (chain),
        .eor_o      (eor),
        .last_o     (seg_last),
        .first_o    (seg_first),
        .beats1_o   (beats1),
        .beats2_o   (beats2),
        .use_buf2_o (use_buf2),
        .len_err_o  (len_err),
        .bytes_o    (bytes)
    );

    pkt_dma_next_ptr #(.AW(AW), .DESC_BYTES(DESC_BYTES)) u_next (
        .cur_i   (q.cur),
        .base_i  (base_i),
        .link_i  (AW'(q.link)),
        .chain_i (chain),
        .eor_i   (eor),
        .next_o  (next_desc)
    );

    always_comb begin
        d     = q;
        d.irq = 1'b0;
        unique case (q.st)
            ST_STOP: if (run_i) begin
                d.cur = {base_i[AW-1:AL], {AL{1'b0}}};
                d.idx = '0;
                d.st  = ST_FETCH;
            end
            ST_FETCH: if (mem_ack_i) begin
                d.idx = q.idx + 2'd1;
                unique case (q.idx)
                    2'd0: if (!mem_rdata_i[OWN_BIT]) d.st = ST_SUSP;
                    2'd1: d.ctrl = mem_rdata_i;
                    2'd2: d.buf1 = mem_rdata_i;
                    default: begin
                        d.link = mem_rdata_i;
                        d.st   = ST_DECODE;
                    end
                endcase
            end
            ST_DECODE: begin
                d.err = len_err;
                d.sof = seg_first;
                d.seg = 2'd0;
                d.st  = len_err ? ST_WB : ST_SEG;
            end
            ST_SEG: begin
                if (q.seg == 2'd0) begin
                    d.seg = 2'd1;
                    if (beats1 != '0) begin
                        d.addr = AW'(q.buf1);
                        d.cnt  = beats1;
                        d.st   = ST_RD;
                    end
                end else if (use_buf2) begin
                    d.seg  = 2'd2;
                    d.addr = AW'(q.link);
                    d.cnt  = beats2;
                    d.st   = ST_RD;
                end else begin
                    d.st = ST_WB;
                end
            end
            ST_RD: if (mem_ack_i) begin
                d.data = mem_rdata_i;
                d.st   = ST_OUT;
            end
            ST_OUT: if (tx_ready_i) begin
                d.sof  = 1'b0;
                d.cnt  = q.cnt - CW'(1);
                d.addr = q.addr + AW'(4);
                if (q.cnt != CW'(1))     d.st = ST_RD;
                else if (q.seg == 2'd2)  d.st = ST_WB;
                else                     d.st = ST_SEG;
            end
            ST_WB: if (mem_ack_i) begin
                d.irq = q.err ? irq_err_en_i : (seg_last && irq_frame_en_i);
                d.cur = next_desc;
                d.idx = '0;
                d.st  = run_i ? ST_FETCH : ST_STOP;
            end
            ST_SUSP: begin
                if (!run_i) d.st = ST_STOP;
                else if (poll_i) begin
                    d.idx = '0;
                    d.st  = ST_FETCH;
                end
            end
            default: d.st = ST_STOP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_STOP;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        mem_req_o   = (q.st == ST_FETCH) || (q.st == ST_RD) || (q.st == ST_WB);
        mem_we_o    = (q.st == ST_WB);
        mem_wdata_o = {1'b0, q.err, {PAD_W{1'b0}}, (q.err ? '0 : bytes)};
        unique case (q.st)
            ST_FETCH: mem_addr_o = {q.cur[AW-1:AL], q.idx, 2'b00};
            ST_WB:    mem_addr_o = q.cur;
            default:  mem_addr_o = q.addr;
        endcase
        tx_valid_o  = (q.st == ST_OUT);
        tx_data_o   = q.data;
        tx_first_o  = (q.st == ST_OUT) && q.sof;
        tx_last_o   = (q.st == ST_OUT) && seg_last && (q.cnt == CW'(1))
                      && ((q.seg == 2'd2) || !use_buf2);
        irq_o       = q.irq;
        stopped_o   = (q.st == ST_STOP);
        suspended_o = (q.st == ST_SUSP);
    end

    // R12
    stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o)
            && $stable(tx_first_o) && $stable(tx_last_o));

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

    // R8
    wb_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_we_o |-> !mem_wdata_o[OWN_BIT] && (mem_addr_o[AL-1:0] == '0));

    // R10
    irq_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(mem_we_o && mem_ack_i));

    // R10
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R11
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stopped_o |-> !mem_req_o && !tx_valid_o);

    // R2
    susp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        suspended_o |-> !mem_req_o && !tx_valid_o && !stopped_o);
endmodule

// File: tb/pkt_dma_engine_test.sv
module pkt_dma_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        poll = 1'b0;
    logic [31:0] base = '0;
    logic        fr_en = 1'b1;
    logic        er_en = 1'b1;
    logic        mem_req_o, mem_we_o;
    logic [31:0] mem_addr_o, mem_wdata_o;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        tx_valid_o, tx_first_o, tx_last_o;
    logic [31:0] tx_data_o;
    logic        tx_ready = 1'b0;
    logic        irq_o, stopped_o, suspended_o;

    always #2 clk = ~clk;

    pkt_dma_engine uut (
        .clk(clk), .rst_n(rst_n), .run_i(run), .poll_i(poll), .base_i(base),
        .irq_frame_en_i(fr_en), .irq_err_en_i(er_en),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
        .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .tx_first_o(tx_first_o),
        .tx_last_o(tx_last_o), .tx_ready_i(tx_ready), .irq_o(irq_o),
        .stopped_o(stopped_o), .suspended_o(suspended_o)
    );

    logic [31:0] mem [0:4095];
    logic [31:0] obs_d [0:1023];
    logic [1:0]  obs_f [0:1023];
    logic [31:0] exp_d [0:1023];
    logic [1:0]  exp_f [0:1023];
    int obs_n = 0, exp_n = 0, irq_cnt = 0;
    int total = 0, bad = 0;
    logic [7:0]  lfsr = 8'h5A;
    logic        pv = 1'b0, pr = 1'b0;
    logic [31:0] pd = '0;

    always @(negedge clk) begin
        lfsr      = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_ack   = mem_req_o && (lfsr[1:0] != 2'b00);
        mem_rdata = mem[mem_addr_o[13:2]];
        tx_ready  = (lfsr[4:2] != 3'b000);
        if (rst_n && pv && !pr) begin
            total++;
            if (!(tx_valid_o && tx_data_o == pd)) begin
                bad++;
                $display("FAIL R12 stall hold act=%h/%0b exp=%h/1", tx_data_o, tx_valid_o, pd);
            end
        end
        pv = tx_valid_o; pr = tx_ready; pd = tx_data_o;
        if (tx_valid_o && tx_ready && obs_n < 1024) begin
            obs_d[obs_n] = tx_data_o;
            obs_f[obs_n] = {tx_first_o, tx_last_o};
            obs_n++;
        end
        if (irq_o) irq_cnt++;
    end

    always @(posedge clk)
        if (rst_n && mem_req_o && mem_we_o && mem_ack)
            mem[mem_addr_o[13:2]] <= mem_wdata_o;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, expv);
        end
    endtask

    task automatic put_desc(input int a, input bit own, input int l1, input int l2,
                            input bit chain, input bit eor, input bit fs, input bit ls,
                            input logic [31:0] b1, input logic [31:0] b3);
        logic [11:0] x1, x2;
        x1 = l1[11:0]; x2 = l2[11:0];
        mem[a/4]     = {own, 31'b0};
        mem[a/4 + 1] = {4'b0, fs, ls, eor, chain, x2, x1};
        mem[a/4 + 2] = b1;
        mem[a/4 + 3] = b3;
    endtask

    function automatic bit is_err(input int l1, input int l2, input bit chain);
        return (l1 > 2048) || (!chain && l2 > 2048);
    endfunction

    // expected beats of one descriptor (R4, R7, R9)
    task automatic exp_desc(input int l1, input int l2, input bit chain, input bit fs,
                            input bit ls, input logic [31:0] b1, input logic [31:0] b2);
        int n1, n2, tot;
        if (is_err(l1, l2, chain)) return;
        n1 = (l1 + 3) / 4;
        n2 = chain ? 0 : (l2 + 3) / 4;
        tot = n1 + n2;
        for (int k = 0; k < tot; k++) begin
            exp_d[exp_n] = (k < n1) ? mem[b1/4 + k] : mem[b2/4 + (k - n1)];
            exp_f[exp_n] = {fs && k == 0, ls && k == tot - 1};
            exp_n++;
        end
    endtask

    task automatic cmp_beats(input string req);
        int m;
        chk(obs_n == exp_n, req, "beat count", obs_n, exp_n);
        m = (obs_n < exp_n) ? obs_n : exp_n;
        for (int i = 0; i < m; i++) begin
            chk(obs_d[i] == exp_d[i], req, $sformatf("beat %0d data", i), obs_d[i], exp_d[i]);
            chk(obs_f[i] == exp_f[i], "R7", $sformatf("beat %0d first/last", i),
                {30'b0, obs_f[i]}, {30'b0, exp_f[i]});
        end
    endtask

    task automatic clear_obs();
        obs_n = 0; exp_n = 0; irq_cnt = 0;
    endtask

    task automatic wait_susp();
        repeat (3) @(negedge clk);
        while (!suspended_o) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic halt();
        run = 1'b0;
        repeat (2) @(negedge clk);
        while (!stopped_o) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lens [6];
        int l1, l2;
        lens = '{0, 1, 3, 4, 5, 8};
        for (int i = 0; i < 4096; i++) mem[i] = 32'hC0DE_0000 + i;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(stopped_o == 1'b1, "R1", "stopped", {31'b0, stopped_o}, 1);
        chk({suspended_o, mem_req_o, tx_valid_o, irq_o} == 4'b0, "R1", "idle outputs",
            {28'b0, suspended_o, mem_req_o, tx_valid_o, irq_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(stopped_o == 1'b1, "R1", "stopped after release", {31'b0, stopped_o}, 1);

        // Scenario A: two-buffer ring, length sweep (R3 R4 R5 R8)
        clear_obs();
        for (int i = 0; i < 36; i++) begin
            l1 = lens[i / 6]; l2 = lens[i % 6];
            put_desc(i * 16, 1, l1, l2, 0, 0, 1, 1, 32'h800 + i * 64, 32'h820 + i * 64);
            exp_desc(l1, l2, 0, 1, 1, 32'h800 + i * 64, 32'h820 + i * 64);
        end
        put_desc(36 * 16, 0, 4, 4, 0, 0, 1, 1, 32'h800, 32'h800);
        base = 32'h0; run = 1'b1;
        wait_susp();
        cmp_beats("R4");
        for (int i = 0; i < 36; i++)
            chk(mem[i * 4] == 32'(lens[i / 6] + lens[i % 6]), "R8",
                $sformatf("status desc %0d", i), mem[i * 4], 32'(lens[i / 6] + lens[i % 6]));
        chk(mem[36 * 4] == 32'h0, "R2", "host-owned desc untouched", mem[36 * 4], 0);
        chk(irq_cnt == 36, "R10", "frame irq count", irq_cnt, 36);
        halt();

        // Scenario B: linked list, frame over three descriptors (R6 R7)
        clear_obs();
        put_desc(32'h500, 1, 12, 7, 1, 0, 1, 0, 32'h2000, 32'h3A7);
        put_desc(32'h3A0, 1, 0, 3000, 1, 0, 0, 0, 32'h2100, 32'h600);
        put_desc(32'h600, 1, 9, 0, 1, 0, 0, 1, 32'h2200, 32'h700);
        put_desc(32'h700, 0, 4, 0, 1, 0, 1, 1, 32'h2300, 32'h0);
        exp_desc(12, 7, 1, 1, 0, 32'h2000, 0);
        exp_desc(0, 3000, 1, 0, 0, 32'h2100, 0);
        exp_desc(9, 0, 1, 0, 1, 32'h2200, 0);
        base = 32'h500; run = 1'b1;
        wait_susp();
        cmp_beats("R6");
        chk(mem[32'h500 / 4] == 32'd12, "R6", "status ignores len2", mem[32'h500 / 4], 12);
        chk(mem[32'h3A0 / 4] == 32'd0, "R6", "masked link, zero len", mem[32'h3A0 / 4], 0);
        chk(mem[32'h600 / 4] == 32'd9, "R8", "status last seg", mem[32'h600 / 4], 9);
        chk(irq_cnt == 1, "R10", "one irq per frame", irq_cnt, 1);
        halt();

        // Scenario C: length limits, error interrupt only (R9 R10)
        clear_obs();
        fr_en = 1'b0; er_en = 1'b1;
        put_desc(32'h000, 1, 2049, 0, 0, 0, 1, 1, 32'h1000, 32'h0);
        put_desc(32'h010, 1, 2048, 0, 0, 0, 1, 1, 32'h1000, 32'h0);
        put_desc(32'h020, 1, 4, 3000, 0, 0, 1, 1, 32'h1000, 32'h1000);
        put_desc(32'h030, 0, 4, 0, 0, 0, 1, 1, 32'h1000, 32'h0);
        exp_desc(2049, 0, 0, 1, 1, 32'h1000, 0);
        exp_desc(2048, 0, 0, 1, 1, 32'h1000, 0);
        exp_desc(4, 3000, 0, 1, 1, 32'h1000, 32'h1000);
        base = 32'h0; run = 1'b1;
        wait_susp();
        cmp_beats("R9");
        chk(mem[0] == 32'h4000_0000, "R9", "status len1 over", mem[0], 32'h4000_0000);
        chk(mem[4] == 32'd2048, "R9", "status 2048 ok", mem[4], 2048);
        chk(mem[8] == 32'h4000_0000, "R9", "status len2 over", mem[8], 32'h4000_0000);
        chk(irq_cnt == 2, "R10", "error irq count", irq_cnt, 2);
        halt();
        fr_en = 1'b1;

        // Scenario D: end-of-ring wrap, then poll (R5 R2)
        clear_obs();
        put_desc(32'h100, 1, 4, 0, 0, 0, 1, 1, 32'h2400, 32'h0);
        put_desc(32'h110, 1, 8, 4, 0, 1, 1, 1, 32'h2500, 32'h2600);
        put_desc(32'h120, 1, 4, 0, 0, 0, 1, 1, 32'h2700, 32'h0);
        exp_desc(4, 0, 0, 1, 1, 32'h2400, 0);
        exp_desc(8, 4, 0, 1, 1, 32'h2500, 32'h2600);
        base = 32'h100; run = 1'b1;
        wait_susp();
        cmp_beats("R5");
        chk(mem[32'h120 / 4] == 32'h8000_0000, "R5", "no step past ring end",
            mem[32'h120 / 4], 32'h8000_0000);
        clear_obs();
        mem[32'h100 / 4] = 32'h8000_0000;
        exp_desc(4, 0, 0, 1, 1, 32'h2400, 0);
        poll = 1'b1;
        @(negedge clk);
        poll = 1'b0;
        wait_susp();
        cmp_beats("R2");
        chk(irq_cnt == 1, "R2", "poll refetch irq", irq_cnt, 1);
        halt();

        // Scenario E: stop after current descriptor (R11)
        clear_obs();
        put_desc(32'h000, 1, 160, 0, 0, 0, 1, 1, 32'h2000, 32'h0);
        put_desc(32'h010, 1, 4, 0, 0, 0, 1, 1, 32'h2400, 32'h0);
        exp_desc(160, 0, 0, 1, 1, 32'h2000, 0);
        base = 32'h0; run = 1'b1;
        while (obs_n == 0) @(negedge clk);
        halt();
        cmp_beats("R11");
        chk(mem[0] == 32'd160, "R11", "current desc written back", mem[0], 160);
        chk(mem[4] == 32'h8000_0000, "R11", "next desc untouched", mem[4], 32'h8000_0000);
        chk(stopped_o == 1'b1, "R11", "stopped", {31'b0, stopped_o}, 1);
        chk(irq_cnt == 1, "R10", "irq before stop", irq_cnt, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule